// File: doc/BRIEF.md
# I2C EEPROM Slave Protocol Engine

This block is the serial front end of a 256-byte EEPROM. The system clock oversamples the two-wire bus lines. Each line goes through a two-flop synchronizer and a three-tap majority filter before any edge is detected. The engine finds Start and Stop conditions and shifts in bytes. It checks the first byte of each command against the fixed device code `1010` and, when enabled, against three strap inputs. It acknowledges addressed bytes and keeps an 8-bit word pointer. It answers reads from a combinational memory read port and hands each written byte, with its address, to a page-write unit outside the block. SDA is driven as an open-drain enable. The output only changes after SCL has been low for a set number of clocks, so the slave cannot itself create a false Start or Stop.

The controller has ten states:

| State | Role |
|---|---|
| `ST_IDLE` | No command is open. |
| `ST_CTRL` | Shifts in the control byte. |
| `ST_CTRL_ACK` | Acknowledges the control byte. |
| `ST_ADDR` | Shifts in the word address. |
| `ST_ADDR_ACK` | Acknowledges the word address. |
| `ST_WDATA` | Shifts in a write data byte. |
| `ST_WDATA_ACK` | Acknowledges a write data byte. |
| `ST_RDATA` | Shifts out a read byte. |
| `ST_RACK` | Samples the master's acknowledge. |
| `ST_IGNORE` | Stays silent until the next Start or Stop. |

Transitions:
- Start moves any state to `ST_CTRL`, and Stop moves any state to `ST_IDLE`.
- At the SCL fall that ends the eighth bit, `ST_CTRL` goes to `ST_CTRL_ACK` on a hit, or to `ST_IGNORE` on a miss.
- At the same point, `ST_ADDR` and `ST_WDATA` go to their acknowledge states, or to `ST_IGNORE` while busy.
- The fall that ends `ST_CTRL_ACK` leads to `ST_RDATA` for a read and to `ST_ADDR` for a write.
- `ST_ADDR_ACK` and `ST_WDATA_ACK` lead to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- `ST_RACK` returns to `ST_RDATA` on a master acknowledge, or goes to `ST_IGNORE` on a no-acknowledge.

Top module: `eep_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high is a Start. It restarts control-byte decoding from any state, including in the middle of a byte. A rising SDA while SCL is high is a Stop and ends the command.
- R2: The control byte is received MSB first. Its bits [7:4] must equal 1010b for the slave to acknowledge. Bit 0 selects read (1) or write (0).
- R3: With `cs_check_en` = 0, control bits [3:1] are ignored. With `cs_check_en` = 1, they must equal `cs_strap[2:0]`, or no acknowledge is given.
- R4: An acknowledge is given by asserting `sda_oe` across the whole ninth clock of a byte.
- R5: In a write, the second byte loads the word pointer. Each later byte is acknowledged and produces a single-cycle `wr_stb` with `wr_addr` = pointer and `wr_data` = byte. The pointer then increments, wrapping from FFh to 00h.
- R6: While `wr_busy` is high when a byte completes, the slave gives no acknowledge for that byte (control byte included) and issues no `wr_stb`.
- R7: A read sends bytes MSB first from `rd_data` with `rd_addr` = pointer. It starts at the current pointer, and the pointer increments by one after each byte, wrapping FFh to 00h.
- R8: After a master no-acknowledge on a read byte, `sda_oe` stays low until the next Start.
- R9: `sda_oe` changes only while SCL is low, and no earlier than `HOLD_CYC` clocks after SCL falls.
- R10: `wr_end` pulses once when a Stop or repeated Start closes a command in which at least one `wr_stb` occurred.
- R11: After reset, `sda_oe`, `wr_stb` and `wr_end` are low and `rd_addr` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cs_check_en | input | 1 | 1 requires control bits [3:1] to match the straps |
| cs_strap | input | 3 | Chip-select strap levels |
| wr_busy | input | 1 | Internal programming cycle in progress |
| rd_addr | output | 8 | Memory read address (word pointer) |
| rd_data | input | 8 | Memory read data for `rd_addr` |
| wr_stb | output | 1 | One-cycle strobe per received data byte |
| wr_addr | output | 8 | Address for the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_end | output | 1 | Pulse when a write command with data closes |

## Verification
A wrong state or bit count shows up at the ports within one byte. It appears as an acknowledge on the wrong clock or for a byte that should be refused, a shifted read byte on the line, or a write strobe with a misplaced address. A pointer that is off shows one byte later, as the wrong `rd_addr` data or `wr_addr`. A hold-timer fault changes `sda_oe` with SCL high or too soon after its fall, and this is caught on the same bit.

// File: rtl/eep_i2c_pkg.sv
package eep_i2c_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [3:0]  DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MAJ_TAPS    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int HALF = MAJ_TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [MAJ_TAPS-1:0]    win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            filt_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            win_q  <= {win_q[MAJ_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            filt_o <= ($countones(win_q) > HALF);
        end
    end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;
    assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2cs_hold_timer.sv
module i2cs_hold_timer #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    output logic upd_ok
);
    localparam int             CW  = $clog2(HOLD_CYC + 2);
    localparam logic [CW-1:0]  LIM = CW'(HOLD_CYC);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              low_cnt <= '0;
        else if (scl_lvl)        low_cnt <= '0;
        else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
    end

    assign upd_ok = !scl_lvl && (low_cnt == LIM);
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_i2c_pkg::*;
#(
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MAJ_TAPS    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              cs_check_en,
    input  logic [2:0]        cs_strap,
    input  logic              wr_busy,
    output logic [BYTE_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_end
);
    // Conditioned bus lines: index 0 = SCL, index 1 = SDA
    logic [1:0] raw_lines, filt_lines;
    logic       scl_f, sda_f;
    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2cs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .MAJ_TAPS(MAJ_TAPS)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw_i(raw_lines[g]), .filt_o(filt_lines[g]));
    end
    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    logic scl_rise, scl_fall, start_ev, stop_ev, upd_ok;

    i2cs_bus_events u_evt (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev));

    i2cs_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_f), .upd_ok(upd_ok));

    slv_state_e        state_q, state_n;
    logic [BYTE_W-1:0] shreg, tx_q, ptr_q;
    logic [2:0]        bitcnt;
    logic              byte_full, rw_q, mst_ack, wr_pend, oe_want;
    logic              ctrl_hit, done_fall;

    assign ctrl_hit  = (shreg[7:4] == DEV_CODE) && !wr_busy &&
                       (!cs_check_en || (shreg[3:1] == cs_strap));
    assign done_fall = scl_fall && byte_full;
    assign rd_addr   = ptr_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        if (start_ev)     state_n = ST_CTRL;
        else if (stop_ev) state_n = ST_IDLE;
        else begin
            unique case (state_q)
                ST_CTRL:      if (done_fall) state_n = ctrl_hit ? ST_CTRL_ACK : ST_IGNORE;
                ST_ADDR:      if (done_fall) state_n = wr_busy ? ST_IGNORE : ST_ADDR_ACK;
                ST_WDATA:     if (done_fall) state_n = wr_busy ? ST_IGNORE : ST_WDATA_ACK;
                ST_CTRL_ACK:  if (scl_fall)  state_n = rw_q ? ST_RDATA : ST_ADDR;
                ST_ADDR_ACK,
                ST_WDATA_ACK: if (scl_fall)  state_n = ST_WDATA;
                ST_RDATA:     if (done_fall) state_n = ST_RACK;
                ST_RACK:      if (scl_fall)  state_n = mst_ack ? ST_RDATA : ST_IGNORE;
                ST_IDLE,
                ST_IGNORE:    state_n = state_q;
                default:      state_n = ST_IDLE;
            endcase
        end
    end

    // Output decode: which level the slave wants on SDA
    always_comb begin
        unique case (state_q)
            ST_CTRL_ACK, ST_ADDR_ACK, ST_WDATA_ACK: oe_want = 1'b1;
            ST_RDATA:                               oe_want = ~tx_q[7];
            default:                                oe_want = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sda_oe <= 1'b0;
        else if (upd_ok) sda_oe <= oe_want;
    end

    // Byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0; tx_q <= '1; ptr_q <= '0; bitcnt <= '0;
            byte_full <= 1'b0; rw_q <= 1'b0; mst_ack <= 1'b0; wr_pend <= 1'b0;
            wr_stb <= 1'b0; wr_end <= 1'b0; wr_addr <= '0; wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            wr_end <= 1'b0;
            if (start_ev || stop_ev) begin
                bitcnt    <= '0;
                byte_full <= 1'b0;
                wr_end    <= wr_pend;
                wr_pend   <= 1'b0;
            end else if (scl_rise) begin
                unique case (state_q)
                    ST_CTRL, ST_ADDR, ST_WDATA: begin
                        shreg     <= {shreg[6:0], sda_f};
                        bitcnt    <= bitcnt + 3'd1;
                        byte_full <= (bitcnt == 3'd7);
                    end
                    ST_RDATA: begin
                        bitcnt    <= bitcnt + 3'd1;
                        byte_full <= (bitcnt == 3'd7);
                    end
                    ST_RACK: mst_ack <= ~sda_f;
                    default: ;
                endcase
            end else if (scl_fall) begin
                unique case (state_q)
                    ST_CTRL: if (byte_full) begin
                        byte_full <= 1'b0;
                        rw_q      <= shreg[0];
                    end
                    ST_ADDR: if (byte_full) begin
                        byte_full <= 1'b0;
                        if (!wr_busy) ptr_q <= shreg;
                    end
                    ST_WDATA: if (byte_full) begin
                        byte_full <= 1'b0;
                        if (!wr_busy) begin
                            wr_stb  <= 1'b1;
                            wr_addr <= ptr_q;
                            wr_data <= shreg;
                            ptr_q   <= ptr_q + 1'b1;
                            wr_pend <= 1'b1;
                        end
                    end
                    ST_CTRL_ACK: begin
                        bitcnt <= '0;
                        if (rw_q) tx_q <= rd_data;
                    end
                    ST_ADDR_ACK, ST_WDATA_ACK: bitcnt <= '0;
                    ST_RDATA: if (byte_full) begin
                        byte_full <= 1'b0;
                        ptr_q     <= ptr_q + 1'b1;
                    end else begin
                        tx_q <= {tx_q[6:0], 1'b1};
                    end
                    ST_RACK: begin
                        bitcnt <= '0;
                        if (mst_ack) tx_q <= rd_data;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk
    import eep_i2c_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_f,
    input logic        sda_oe,
    input logic        wr_busy,
    input logic        wr_stb,
    input logic [7:0]  rd_addr,
    input slv_state_e  state_q
);
    localparam int CW = $clog2(HOLD_CYC + 2);

    int unsigned low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    low_run <= 0;
        else if (scl_f)                low_run <= 0;
        else if (low_run < HOLD_CYC)   low_run <= low_run + 1;
    end

    AST_OE_HOLD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_f) && $past(low_run) >= HOLD_CYC)); // R9

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R5

    AST_NO_STB_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$past(wr_busy)); // R6

    AST_PTR_STABLE_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDATA && $past(state_q) == ST_RDATA) |-> $stable(rd_addr)); // R7

    AST_SILENT_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE && $past(state_q) == ST_IGNORE && !$past(sda_oe)) |-> !sda_oe); // R8
endmodule

bind eep_i2c_slave eep_i2c_slave_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe), .wr_busy(wr_busy),
    .wr_stb(wr_stb), .rd_addr(rd_addr), .state_q(state_q));

// File: tb/test_eep_i2c_slave.sv
`timescale 1ns/1ps
module test_eep_i2c_slave;
    localparam int HOLD = 4;
    localparam int Q    = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe, cs_check_en = 1'b0, wr_busy = 1'b0;
    logic [2:0] cs_strap = 3'b000;
    logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
    logic       wr_stb, wr_end;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = rd_addr ^ 8'h5A;

    eep_i2c_slave #(.HOLD_CYC(HOLD)) i_eep_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .cs_check_en(cs_check_en), .cs_strap(cs_strap), .wr_busy(wr_busy),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_end(wr_end));

    int checks = 0, fails = 0;
    int stb_n = 0, end_n = 0, hold_bad = 0, low_run = 0;
    logic [7:0] stb_a [64];
    logic [7:0] stb_d [64];
    logic oe_prev = 1'b0;

    always @(posedge clk) begin
        if (wr_stb) begin
            stb_a[stb_n % 64] <= wr_addr;
            stb_d[stb_n % 64] <= wr_data;
            stb_n <= stb_n + 1;
        end
        if (wr_end) end_n <= end_n + 1;
    end

    // R9 monitor: SDA enable may move only with SCL low for HOLD clocks
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && (scl || low_run < HOLD)) hold_bad++;
        low_run = scl ? 0 : low_run + 1;
        oe_prev = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] memv(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output bit acked);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        acked = !sda_line;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic get_byte(output logic [7:0] v, input bit give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl = 1'b1; wq(); v[i] = sda_line; wq(); scl = 1'b0;
        end
        wq();
        sda_m = !give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    // {ctrl[7:0], cs_check_en, strap[2:0], expect_ack}
    localparam logic [12:0] VEC [8] = '{
        {8'hA0, 1'b0, 3'b000, 1'b1},
        {8'hA6, 1'b0, 3'b000, 1'b1},
        {8'hB0, 1'b0, 3'b000, 1'b0},
        {8'h20, 1'b0, 3'b000, 1'b0},
        {8'hAA, 1'b1, 3'b101, 1'b1},
        {8'hA2, 1'b1, 3'b101, 1'b0},
        {8'hAE, 1'b1, 3'b111, 1'b1},
        {8'hAC, 1'b1, 3'b111, 1'b0}
    };

    bit         ack;
    logic [7:0] rv;
    int         sb, eb;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R11 sda_oe", int'(sda_oe), 0);
        chk(wr_stb == 1'b0 && wr_end == 1'b0, "R11 strobes", int'({wr_stb, wr_end}), 0);
        chk(rd_addr == 8'h00, "R11 rd_addr", int'(rd_addr), 0);

        // Control-byte matching table (R2, R3, R4)
        for (int k = 0; k < 8; k++) begin
            cs_check_en = VEC[k][4];
            cs_strap    = VEC[k][3:1];
            bus_start();
            put_byte(VEC[k][12:5], ack);
            chk(ack == VEC[k][0], "R2/R3/R4 control ack", int'(ack), int'(VEC[k][0]));
            bus_stop();
        end
        cs_check_en = 1'b0;

        // R5 page of three bytes with pointer wrap, R10 end pulse
        sb = stb_n; eb = end_n;
        bus_start();
        put_byte(8'hA0, ack); chk(ack, "R4 write ctrl ack", int'(ack), 1);
        put_byte(8'hFE, ack); chk(ack, "R5 addr ack", int'(ack), 1);
        put_byte(8'h11, ack); chk(ack, "R5 data ack", int'(ack), 1);
        put_byte(8'h22, ack);
        put_byte(8'h33, ack); chk(ack, "R5 data ack", int'(ack), 1);
        bus_stop();
        repeat (10) @(negedge clk);
        chk(stb_n - sb == 3, "R5 strobe count", stb_n - sb, 3);
        chk(stb_a[sb % 64] == 8'hFE && stb_d[sb % 64] == 8'h11, "R5 first byte",
            int'({stb_a[sb % 64], stb_d[sb % 64]}), 16'hFE11);
        chk(stb_a[(sb + 1) % 64] == 8'hFF && stb_d[(sb + 1) % 64] == 8'h22, "R5 second byte",
            int'({stb_a[(sb + 1) % 64], stb_d[(sb + 1) % 64]}), 16'hFF22);
        chk(stb_a[(sb + 2) % 64] == 8'h00 && stb_d[(sb + 2) % 64] == 8'h33, "R5 wrapped byte",
            int'({stb_a[(sb + 2) % 64], stb_d[(sb + 2) % 64]}), 16'h0033);
        chk(end_n - eb == 1, "R10 wr_end on Stop", end_n - eb, 1);

        // R7 current-address read from pointer 01h, R8 release after NACK
        bus_start();
        put_byte(8'hA1, ack); chk(ack, "R7 read ctrl ack", int'(ack), 1);
        get_byte(rv, 1'b1); chk(rv == memv(8'h01), "R7 byte 01", int'(rv), int'(memv(8'h01)));
        get_byte(rv, 1'b0); chk(rv == memv(8'h02), "R7 byte 02", int'(rv), int'(memv(8'h02)));
        chk(sda_oe == 1'b0, "R8 released after NACK", int'(sda_oe), 0);
        wq(); scl = 1'b1; wq();
        chk(sda_line == 1'b1, "R8 line high on extra clock", int'(sda_line), 1);
        wq(); scl = 1'b0; wq();
        bus_stop();

        // R1 repeated Start for random read, R7 wrap FFh to 00h, R10 no end pulse
        eb = end_n;
        bus_start();
        put_byte(8'hA0, ack);
        put_byte(8'hFF, ack); chk(ack, "R1 address before restart", int'(ack), 1);
        bus_start();
        put_byte(8'hA1, ack); chk(ack, "R1 ctrl after repeated Start", int'(ack), 1);
        get_byte(rv, 1'b1); chk(rv == memv(8'hFF), "R7 byte FF", int'(rv), int'(memv(8'hFF)));
        get_byte(rv, 1'b0); chk(rv == memv(8'h00), "R7 wrapped byte 00", int'(rv), int'(memv(8'h00)));
        bus_stop();
        repeat (10) @(negedge clk);
        chk(end_n == eb, "R10 no end without data", end_n - eb, 0);

        // R1 Start in the middle of a control byte
        sb = stb_n; eb = end_n;
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte(8'hA0, ack); chk(ack, "R1 ctrl after mid-byte Start", int'(ack), 1);
        put_byte(8'h10, ack);
        put_byte(8'h77, ack); chk(ack, "R5 data after restart", int'(ack), 1);
        bus_start();
        repeat (5) @(negedge clk);
        chk(end_n - eb == 1, "R10 wr_end on repeated Start", end_n - eb, 1);
        chk(stb_n - sb == 1 && stb_a[sb % 64] == 8'h10 && stb_d[sb % 64] == 8'h77, "R5 strobe",
            int'({stb_a[sb % 64], stb_d[sb % 64]}), 16'h1077);
        put_byte(8'hA1, ack);
        get_byte(rv, 1'b0); chk(rv == memv(8'h11), "R7 byte after write", int'(rv), int'(memv(8'h11)));
        bus_stop();

        // R6 busy suppresses every acknowledge and strobe
        sb = stb_n;
        wr_busy = 1'b1;
        bus_start();
        put_byte(8'hA0, ack); chk(!ack, "R6 ctrl while busy", int'(ack), 0);
        bus_stop();
        wr_busy = 1'b0;
        bus_start();
        put_byte(8'hA0, ack); chk(ack, "R6 ctrl when idle", int'(ack), 1);
        wr_busy = 1'b1;
        put_byte(8'h20, ack); chk(!ack, "R6 addr while busy", int'(ack), 0);
        put_byte(8'h55, ack); chk(!ack, "R6 data while busy", int'(ack), 0);
        wr_busy = 1'b0;
        bus_stop();
        repeat (10) @(negedge clk);
        chk(stb_n == sb, "R6 no strobe while busy", stb_n - sb, 0);

        chk(hold_bad == 0, "R9 SDA hold after SCL fall", hold_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule